// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Data Cache

This block is a data cache placed between a processor load/store port and a main-memory port. The processor side carries a 32-bit byte address, a 32-bit word in each direction, separate read and write strobes, a hit indication and a busy output. The memory side carries a 32-bit address, a 128-bit line in each direction, separate read and write requests and a single ready acknowledge. Each set holds two ways. Each way keeps a 16-byte line of four words, a tag and a valid flag.

A read that finds its line answers in the same cycle with no memory traffic. A read that misses holds busy high, fetches the whole line in one memory transfer, installs it in a way of the set and hands the requested word straight from the incoming line to the processor. Every write goes to memory. A write that finds its line also patches the one addressed word in the cache. A write that misses leaves the cache alone. The set-index width is a parameter. With an index width of 13 there are 8192 sets and a 15-bit tag, for 256 KB of data. In that configuration, address 0x0F3F4024 lands in set 0x1402, word 1, with tag 0x079F.

The processor holds its strobe, address and write data steady until it sees busy low. The cycle in which busy is low is the cycle that carries the result.

Top module: `wt_cache2`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. While no strobe is raised, busy, hit and both memory requests are low.
- R2: The address splits into fields. The word select is bits [3:2]. The set index is bits [IDX_W+3:4]. The tag is bits [31:IDX_W+4]. Bits [1:0] have no effect on which word is returned.
- R3: A read hit needs three things at once: a valid way, a matching tag, and a raised read strobe. On a read hit, hit is 1 and busy is 0 in that same cycle, read data is the addressed word, and no memory request is made.
- R4: On a read miss, hit is 0 and busy is 1. The block then raises the memory read request with the line-aligned address (low four bits zero) and keeps it steady until ready. In the ready cycle busy drops and read data is word [3:2] of the incoming line. Word k of a line occupies bits [32k+31:32k].
- R5: A refill installs the line, its tag and a set valid flag, so that later reads of any word of that line hit and return memory's contents.
- R6: The refill way is chosen in this order: way 0 if it is invalid, else way 1 if it is invalid, else the way the set's recency bit names. A read hit or a refill makes the recency bit name the other way.
- R7: A write raises the memory write request with the full processor address and the word copied into all four 32-bit lanes. Busy stays high until ready, and memory then holds the word.
- R8: A write hit updates only the addressed word of the matching way. A write miss changes no cache state, so a later read of that line misses. No write causes a memory read.
- R9: Hit is never raised for a write, and at most one way matches any address.
- R10: The memory read and write requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 32 | Processor byte address |
| cpuWData | input | 32 | Processor write word |
| cpuRd | input | 1 | Read strobe, held until busy is low |
| cpuWr | input | 1 | Write strobe, held until busy is low |
| cpuRData | output | 32 | Read word, valid when busy is low |
| cpuHit | output | 1 | Read hit indication |
| cpuBusy | output | 1 | Processor must hold its request |
| memAddr | output | 32 | Memory address (line-aligned for fetches) |
| memWData | output | 128 | Write word replicated on four lanes |
| memRd | output | 1 | Line fetch request |
| memWr | output | 1 | Word write request |
| memRData | input | 128 | Fetched line |
| memReady | input | 1 | Memory acknowledge for the current request |

## Verification
The bench runs with eight sets and sweeps every set with two and then three competing tags. This exposes a victim choice that ignores an invalid way or has its recency sense inverted: such a design evicts the line just used, and a read the reference predicts as a hit comes back as a miss. Write hits and write misses are interleaved with reads of neighbouring words. A design that allocates on a write miss reports a hit where a miss is expected, and one that patches the whole line corrupts the neighbouring words against the flat reference memory. A long pseudo-random mix with varying memory latency and nonzero byte offsets checks that the word is forwarded from the incoming line, not from the stale way, and that no stray memory read is issued on a hit or a write.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int OFFS_W     = 4;
  localparam int NUM_WAYS   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic fillLine;   // install incoming line into victim way
    logic wordUpd;    // patch addressed word in matching way
    logic lruTouch;   // read hit: steer recency away from hit way
    logic fwdRefill;  // return word from incoming line
    logic lineAddr;   // present line-aligned address to memory
  } ctlStrobe_t;
endpackage

// File: rtl/wt_cache_way.sv
module wt_cache_way
  import wt_cache_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 32 - IDX_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic              fillEn,
  input  logic [LINE_W-1:0] fillData,
  input  logic              wordEn,
  input  logic [1:0]        wordSel,
  input  logic [WORD_W-1:0] wordData,
  output logic              match,
  output logic              valid,
  output logic [LINE_W-1:0] lineOut
);
  localparam int SETS = 1 << IDX_W;

  logic [LINE_W-1:0] dataArr [SETS];
  logic [TAG_W-1:0]  tagArr  [SETS];
  logic [SETS-1:0]   vldArr;

  always_ff @(posedge clk) begin
    if (!rstN) vldArr <= '0;
    else if (fillEn) vldArr[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      dataArr[idx] <= fillData;
      tagArr[idx]  <= lookTag;
    end else if (wordEn) begin
      dataArr[idx][{wordSel, 5'b0} +: WORD_W] <= wordData;
    end
  end

  assign valid   = vldArr[idx];
  assign match   = valid && (tagArr[idx] == lookTag);
  assign lineOut = dataArr[idx];

  // R8: a word patch only lands in a way that holds the line
  a_r8_patch_on_match: assert property (@(posedge clk) disable iff (!rstN)
    wordEn |-> match);
  // R9: refill never targets a way that already matches
  a_r9_fill_non_matching: assert property (@(posedge clk) disable iff (!rstN)
    fillEn |-> !match);
endmodule

// File: rtl/wt_cache_dp.sv
module wt_cache_dp
  import wt_cache_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  input  logic              cpuRd,
  input  logic [LINE_W-1:0] memRData,
  input  ctlStrobe_t        ctl,
  output logic              readHit,
  output logic [WORD_W-1:0] cpuRData,
  output logic [31:0]       memAddr,
  output logic [LINE_W-1:0] memWData
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = 32 - IDX_W - OFFS_W;

  logic [TAG_W-1:0]  addrTag;
  logic [IDX_W-1:0]  addrIdx;
  logic [1:0]        addrWord;
  logic [NUM_WAYS-1:0] matchV;
  logic [NUM_WAYS-1:0] vldV;
  logic [LINE_W-1:0] wayLine [NUM_WAYS];
  logic [SETS-1:0]   lruArr;
  logic              victim;
  logic [LINE_W-1:0] hitLine;
  logic [LINE_W-1:0] srcLine;

  assign addrTag  = cpuAddr[31 -: TAG_W];
  assign addrIdx  = cpuAddr[IDX_W+OFFS_W-1 : OFFS_W];
  assign addrWord = cpuAddr[3:2];

  always_comb begin
    if (!vldV[0])      victim = 1'b0;
    else if (!vldV[1]) victim = 1'b1;
    else               victim = lruArr[addrIdx];
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    wt_cache_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk      (clk),
      .rstN     (rstN),
      .idx      (addrIdx),
      .lookTag  (addrTag),
      .fillEn   (ctl.fillLine && (victim == 1'(w))),
      .fillData (memRData),
      .wordEn   (ctl.wordUpd && matchV[w]),
      .wordSel  (addrWord),
      .wordData (cpuWData),
      .match    (matchV[w]),
      .valid    (vldV[w]),
      .lineOut  (wayLine[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) lruArr <= '0;
    else if (ctl.lruTouch) lruArr[addrIdx] <= matchV[0];
    else if (ctl.fillLine) lruArr[addrIdx] <= ~victim;
  end

  assign readHit  = cpuRd && (|matchV);
  assign hitLine  = matchV[1] ? wayLine[1] : wayLine[0];
  assign srcLine  = ctl.fwdRefill ? memRData : hitLine;
  assign cpuRData = srcLine[{addrWord, 5'b0} +: WORD_W];
  assign memAddr  = ctl.lineAddr ? {cpuAddr[31:OFFS_W], {OFFS_W{1'b0}}} : cpuAddr;
  assign memWData = {LINE_WORDS{cpuWData}};

  // R9: one way at most holds a given line
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $countones(matchV) <= 1);
  // R3: recency is touched only by a genuine read hit
  a_r3_touch_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lruTouch |-> readHit);
  // R4: fetch addresses are line aligned
  a_r4_aligned_fetch: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineAddr |-> (memAddr[OFFS_W-1:0] == '0));
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuRd,
  input  logic       cpuWr,
  input  logic       readHit,
  input  logic       memReady,
  output logic       cpuHit,
  output logic       cpuBusy,
  output logic       memRd,
  output logic       memWr,
  output ctlStrobe_t ctl
);
  ctlState_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext  = st;
    ctl     = '0;
    cpuBusy = 1'b0;
    cpuHit  = 1'b0;
    memRd   = 1'b0;
    memWr   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (cpuRd) begin
          if (readHit) begin
            cpuHit       = 1'b1;
            ctl.lruTouch = 1'b1;
          end else begin
            cpuBusy = 1'b1;
            stNext  = ST_FILL;
          end
        end else if (cpuWr) begin
          cpuBusy = 1'b1;
          stNext  = ST_WRITE;
        end
      end
      ST_FILL: begin
        memRd        = 1'b1;
        ctl.lineAddr = 1'b1;
        cpuBusy      = !memReady;
        if (memReady) begin
          ctl.fillLine  = 1'b1;
          ctl.fwdRefill = 1'b1;
          stNext        = ST_IDLE;
        end
      end
      ST_WRITE: begin
        memWr   = 1'b1;
        cpuBusy = !memReady;
        if (memReady) begin
          ctl.wordUpd = 1'b1;
          stNext      = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  // R4: fetch request held until acknowledged
  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> memRd);
  // R7: write request held until acknowledged
  a_r7_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memReady) |=> memWr);
  // R10: never both requests
  a_r10_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R1: idle and unrequested means quiet
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !cpuRd && !cpuWr) |-> (!cpuBusy && !memRd && !memWr));
endmodule

// File: rtl/wt_cache2.sv
module wt_cache2
  import wt_cache_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [31:0]  cpuAddr,
  input  logic [31:0]  cpuWData,
  input  logic         cpuRd,
  input  logic         cpuWr,
  output logic [31:0]  cpuRData,
  output logic         cpuHit,
  output logic         cpuBusy,
  output logic [31:0]  memAddr,
  output logic [127:0] memWData,
  output logic         memRd,
  output logic         memWr,
  input  logic [127:0] memRData,
  input  logic         memReady
);
  ctlStrobe_t ctl;
  logic       readHit;

  wt_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuRd    (cpuRd),
    .cpuWr    (cpuWr),
    .readHit  (readHit),
    .memReady (memReady),
    .cpuHit   (cpuHit),
    .cpuBusy  (cpuBusy),
    .memRd    (memRd),
    .memWr    (memWr),
    .ctl      (ctl)
  );

  wt_cache_dp #(.IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .cpuWData (cpuWData),
    .cpuRd    (cpuRd),
    .memRData (memRData),
    .ctl      (ctl),
    .readHit  (readHit),
    .cpuRData (cpuRData),
    .memAddr  (memAddr),
    .memWData (memWData)
  );

  // R3: a hit answers at once with no memory traffic
  a_r3_hit_immediate: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> (!cpuBusy && !memRd && !memWr));
  // R9: writes never report a hit
  a_r9_write_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuRd) |-> !cpuHit);
endmodule

// File: tb/wt_cache2_bench.sv
module wt_cache2_bench;
  localparam int IDX_W = 3;
  localparam int WORDS = 128;   // flat space: addresses 0..511, tags 0..3

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  cpuAddr = '0, cpuWData = '0;
  logic         cpuRd = 1'b0, cpuWr = 1'b0;
  logic [31:0]  cpuRData;
  logic         cpuHit, cpuBusy;
  logic [31:0]  memAddr;
  logic [127:0] memWData;
  logic         memRd, memWr;
  logic [127:0] memRData = '0;
  logic         memReady = 1'b0;

  always #4 clk = ~clk;

  wt_cache2 #(.IDX_W(IDX_W)) u_wt_cache2 (.*);

  logic [31:0] memArr [WORDS];
  logic [31:0] refArr [WORDS];
  int  mTag [8][2];
  bit  mVal [8][2];
  int  mLru [8];
  int  testCnt = 0, failCnt = 0;
  int  rdXfers = 0, bothSeen = 0, latSel = 0, waitCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  // memory model
  always @(posedge clk) begin
    if (memRd && memWr) bothSeen++;
    if (!rstN) begin
      memReady <= 1'b0; waitCnt = 0;
    end else if (memReady) begin
      memReady <= 1'b0; waitCnt = 0;
    end else if (memRd || memWr) begin
      if (waitCnt >= latSel % 3) begin
        memReady <= 1'b1;
        latSel++;
        if (memRd) begin
          for (int k = 0; k < 4; k++)
            memRData[32*k +: 32] <= memArr[(memAddr[8:4] * 4) + k];
          rdXfers++;
        end else begin
          memArr[memAddr[8:2]] = memWData[32*memAddr[3:2] +: 32];
        end
      end else waitCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input bit isWr, input logic [31:0] addr, input logic [31:0] wd, input string ph);
    int s, t, wi, hw, guard, rdBefore, v;
    s = int'(addr[6:4]); t = int'(addr[8:7]); wi = int'(addr[8:2]);
    hw = -1;
    for (int w = 0; w < 2; w++) if (mVal[s][w] && mTag[s][w] == t) hw = w;
    rdBefore = rdXfers;
    @(negedge clk);
    cpuAddr = addr; cpuWData = wd; cpuRd = !isWr; cpuWr = isWr;
    #1;
    guard = 0;
    while (cpuBusy && guard < 100) begin @(negedge clk); #1; guard++; end
    chk(guard < 100, {ph, " R4 busy timeout"}, guard, 0);
    if (!isWr) begin
      chk(cpuHit == (hw >= 0), {ph, " R6 hit flag"}, cpuHit, hw >= 0);
      chk(cpuRData == refArr[wi], {ph, (hw >= 0) ? " R3 hit data" : " R4 forwarded data"},
          cpuRData, refArr[wi]);
    end else begin
      chk(!cpuHit, {ph, " R9 write hit flag"}, cpuHit, 0);
      chk(memWr && memReady, {ph, " R7 write ack"}, {memWr, memReady}, 2'b11);
      chk(memWData == {4{wd}}, {ph, " R7 lanes"}, memWData, {4{wd}});
      chk(memAddr == addr, {ph, " R7 address"}, memAddr, addr);
    end
    @(posedge clk); #1;
    cpuRd = 1'b0; cpuWr = 1'b0;
    if (isWr) begin
      refArr[wi] = wd;
      chk(rdXfers == rdBefore, {ph, " R8 no fetch on write"}, rdXfers - rdBefore, 0);
      chk(memArr[wi] == wd, {ph, " R7 memory word"}, memArr[wi], wd);
    end else begin
      chk(rdXfers - rdBefore == ((hw >= 0) ? 0 : 1), {ph, " R3 fetch count"},
          rdXfers - rdBefore, (hw >= 0) ? 0 : 1);
      if (hw >= 0) mLru[s] = 1 - hw;
      else begin
        v = !mVal[s][0] ? 0 : (!mVal[s][1] ? 1 : mLru[s]);
        mVal[s][v] = 1'b1; mTag[s][v] = t; mLru[s] = 1 - v;
      end
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int w, input int b);
    return 32'(t * 128 + s * 16 + w * 4 + b);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog R1", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      memArr[i] = 32'hC0DE0000 ^ (32'(i) * 32'h01030507);
      refArr[i] = memArr[i];
    end
    for (int s = 0; s < 8; s++) begin
      mVal[s][0] = 0; mVal[s][1] = 0; mTag[s][0] = 0; mTag[s][1] = 0; mLru[s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!cpuBusy, "R1 busy after reset", cpuBusy, 0);
    chk(!cpuHit,  "R1 hit after reset", cpuHit, 0);
    chk(!memRd && !memWr, "R1 requests after reset", {memRd, memWr}, 0);

    // first touch of every set misses; fill both ways
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 8; s++) doOp(0, mk(t, s, s % 4, 0), 0, "R1");
    // every word of both lines now hits
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < 4; w++) doOp(0, mk(t, s, w, 0), 0, "R5");
    // replacement order under conflict
    for (int s = 0; s < 8; s++) begin
      doOp(0, mk(0, s, 1, 0), 0, "R6");
      doOp(0, mk(2, s, 2, 0), 0, "R6");
      doOp(0, mk(1, s, 3, 0), 0, "R6");
      doOp(0, mk(2, s, 0, 0), 0, "R6");
      doOp(0, mk(0, s, 0, 0), 0, "R6");
    end
    // write hit and write miss
    for (int s = 0; s < 8; s++) begin
      doOp(1, mk(2, s, 1, 0), 32'hBEEF0000 + 32'(s), "R8");
      doOp(1, mk(3, s, 2, 0), 32'hFACE0000 + 32'(s), "R8");
      doOp(0, mk(2, s, 1, 0), 0, "R8");
      doOp(0, mk(2, s, 0, 0), 0, "R8");
      doOp(0, mk(3, s, 2, 0), 0, "R8");
    end
    // byte offset ignored
    for (int b = 0; b < 4; b++) doOp(0, mk(3, 5, 2, b), 0, "R2");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doOp(lfsr[15:13] < 3'd2, {23'b0, lfsr[8:0]}, {lfsr, ~lfsr}, "R2");
    end
    chk(bothSeen == 0, "R10 both requests", bothSeen, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule